// File: doc/BRIEF.md
# Staggered Multichannel Grayscale PWM Generator

This block turns a set of per-channel 12-bit brightness codes into per-channel on/off enables for constant-current sinks. A single shared grayscale counter advances once per pulse on a grayscale step strobe, which is synchronous to the system clock. A channel is lit while the counter is below that channel's code. A frame is started only by a blank pulse. While blank is high, every enable is forced low, the counter returns to zero, and the codes are copied into shadow registers. The lit pattern cannot change in the middle of a frame.

The frame runs once. When the counter has reached 4095 and one more step arrives, all enables stay low until the next blank pulse. Each channel's enable is delayed by one system clock per channel index, so the channels switch at different instants. An active-low error output merges a thermal flag with per-channel open-load flags. An open-load flag counts only while its own channel is lit.

The sequencer has three states. BLANKED is the reset state: it is held while blank is high and moves to RUNNING on the first clock with blank low. RUNNING counts steps and moves to EXHAUSTED when a step arrives with the counter at 4095. EXHAUSTED holds until blank returns. From either RUNNING or EXHAUSTED, blank high moves the sequencer back to BLANKED.

Top module: `gspwm_core`

## Requirements
- R1: While reset is asserted and directly after it, every `pwm_en` bit is 0 and `err_n` is 1.
- R2: With code L (1 to 4094) and one step every P clocks, channel k's enable is high for exactly L*P clocks per frame. It is on while the counter, which starts at 0, is below L.
- R3: A channel whose code is 0 is never lit during the frame.
- R4: A channel with code 4095 is lit for 4095*P clocks. After the counter passes 4095, all enables stay 0 until the next blank pulse.
- R5: The sequencer enters RUNNING at the first clock edge with blank low. Channel k's enable first rises k+1 clocks after that edge, so adjacent channels are offset by one clock.
- R6: At the first clock edge where blank is sampled high, every enable goes to 0 and the counter returns to 0.
- R7: Step pulses that arrive while blanked do not advance the counter. The next frame's on-times are still L*P clocks.
- R8: Codes are captured only while blanked. A code change in the middle of a frame has no effect until the next blank pulse.
- R9: Thermal flag high drives `err_n` to 0 one clock later, whatever the enables are.
- R10: Open-load bit k drives `err_n` to 0 one clock later only if `pwm_en[k]` is high. Otherwise it is ignored.
- R11: `err_n` returns to 1 one clock after every error cause has gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | Forces enables off, clears the counter, starts the next frame when it falls |
| gs_step | input | 1 | Grayscale step strobe, one clock wide |
| gs_level | input | CH*GSW | Packed codes, channel k at bits k*GSW upward |
| open_load | input | CH | Per-channel open-load flags |
| thermal | input | 1 | Over-temperature flag |
| pwm_en | output | CH | Staggered per-channel enables |
| err_n | output | 1 | Active-low merged error |

## Verification
Blank and a grayscale step can land in the same clock. When they do, blank must win: the counter stays at zero and the step is lost. Each frame is preceded by a blank interval in which the step strobe toggles on alternate clocks, so these two events coincide repeatedly. The outcome is judged by the on-time of every channel in the following frame. Any leaked step shortens that on-time below L*P. A second collision, between an open-load flag and the staggered enable of its channel, is provoked by raising the flag on lit and unlit channels and reading `err_n` one clock later.

// File: rtl/gspwm_pkg.sv
package gspwm_pkg;
    typedef enum logic [1:0] {
        S_BLANKED   = 2'd0,
        S_RUNNING   = 2'd1,
        S_EXHAUSTED = 2'd2
    } gs_state_e;
endpackage

// File: rtl/gspwm_seq.sv
module gspwm_seq
    import gspwm_pkg::*;
#(
    parameter int GSW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blank,
    input  logic           gs_step,
    output logic [GSW-1:0] cnt,
    output logic           run,
    output logic           load
);
    localparam logic [GSW-1:0] CNT_MAX = '1;

    gs_state_e st, st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_BLANKED;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_BLANKED:   st_nxt = blank ? S_BLANKED : S_RUNNING;
            S_RUNNING: begin
                if (blank)                           st_nxt = S_BLANKED;
                else if (gs_step && cnt == CNT_MAX)  st_nxt = S_EXHAUSTED;
            end
            S_EXHAUSTED: st_nxt = blank ? S_BLANKED : S_EXHAUSTED;
            default:     st_nxt = S_BLANKED;
        endcase
    end

    // shared grayscale counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          cnt <= '0;
        else if (blank)                                      cnt <= '0;
        else if (st == S_RUNNING && gs_step && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // outputs
    always_comb begin
        run  = (st == S_RUNNING);
        load = (st == S_BLANKED);
    end

    // R6
    blank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (cnt == '0 && st == S_BLANKED));
    // R7
    step_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BLANKED) |=> (cnt == '0));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXHAUSTED && !blank) |=> ($stable(cnt) && st == S_EXHAUSTED));
endmodule

// File: rtl/gspwm_chan.sv
module gspwm_chan #(
    parameter int GSW = 12,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blank,
    input  logic           load,
    input  logic           run,
    input  logic [GSW-1:0] cnt,
    input  logic [GSW-1:0] level,
    output logic           pwm
);
    localparam int PW = IDX + 1;

    logic [GSW-1:0] shadow;
    logic [PW-1:0]  pipe;
    logic           raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= level;
    end

    always_comb raw = run && (cnt < shadow);

    generate
        if (IDX == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     pipe <= '0;
                else if (blank) pipe <= '0;
                else            pipe <= raw;
            end
        end else begin : g_later
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     pipe <= '0;
                else if (blank) pipe <= '0;
                else            pipe <= {pipe[PW-2:0], raw};
            end
        end
    endgenerate

    always_comb pwm = pipe[PW-1];

    // R6
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !pwm);
    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow));
endmodule

// File: rtl/gspwm_fault.sv
module gspwm_fault #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] open_load,
    input  logic [CH-1:0] pwm,
    input  logic          thermal,
    output logic          err_n
);
    logic cause;

    always_comb cause = thermal || (|(open_load & pwm));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_n <= 1'b1;
        else        err_n <= !cause;
    end

    // R9
    therm_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal |=> !err_n);
    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> $past(thermal || (|(open_load & pwm))));
endmodule

// File: rtl/gspwm_core.sv
module gspwm_core #(
    parameter int CH  = 16,
    parameter int GSW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank,
    input  logic              gs_step,
    input  logic [CH*GSW-1:0] gs_level,
    input  logic [CH-1:0]     open_load,
    input  logic              thermal,
    output logic [CH-1:0]     pwm_en,
    output logic              err_n
);
    logic [GSW-1:0] cnt;
    logic           run;
    logic           load;

    gspwm_seq #(.GSW(GSW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank   (blank),
        .gs_step (gs_step),
        .cnt     (cnt),
        .run     (run),
        .load    (load)
    );

    generate
        for (genvar k = 0; k < CH; k++) begin : g_ch
            gspwm_chan #(.GSW(GSW), .IDX(k)) u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .blank (blank),
                .load  (load),
                .run   (run),
                .cnt   (cnt),
                .level (gs_level[k*GSW +: GSW]),
                .pwm   (pwm_en[k])
            );
        end
    endgenerate

    gspwm_fault #(.CH(CH)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_load (open_load),
        .pwm       (pwm_en),
        .thermal   (thermal),
        .err_n     (err_n)
    );
endmodule

// File: tb/gspwm_core_tb.sv
`timescale 1ns/1ps
module gspwm_core_tb;
    localparam int CH  = 16;
    localparam int GSW = 12;

    typedef struct {
        int    ch;
        int    on_cnt;
        int    rise;
        string tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              blank;
    logic              gs_step;
    logic [CH*GSW-1:0] gs_level;
    logic [CH-1:0]     open_load;
    logic              thermal;
    logic [CH-1:0]     pwm_en;
    logic              err_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int frame_id = 0;
    int done_id  = 0;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gspwm_core #(.CH(CH), .GSW(GSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .blank(blank), .gs_step(gs_step),
        .gs_level(gs_level), .open_load(open_load), .thermal(thermal),
        .pwm_en(pwm_en), .err_n(err_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // monitor: measures on-time and first rise per channel, pops the scoreboard
    int mcnt [CH];
    int mrise[CH];
    int moff;
    int seen_id   = 0;
    int seen_done = 0;
    always @(negedge clk) begin
        if (frame_id != seen_id) begin
            seen_id = frame_id;
            moff = 0;
            for (int k = 0; k < CH; k++) begin mcnt[k] = 0; mrise[k] = -1; end
        end else begin
            moff++;
            for (int k = 0; k < CH; k++)
                if (pwm_en[k]) begin
                    mcnt[k]++;
                    if (mrise[k] < 0) mrise[k] = moff;
                end
        end
        if (done_id != seen_done) begin
            seen_done = done_id;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(mcnt[it.ch] == it.on_cnt,
                      $sformatf("%s ch%0d on-time", it.tag, it.ch), mcnt[it.ch], it.on_cnt);
                check(mrise[it.ch] == it.rise,
                      $sformatf("R5 ch%0d first rise", it.ch), mrise[it.ch], it.rise);
            end
        end
    end

    task automatic set_levels(input int lv[CH]);
        for (int k = 0; k < CH; k++) gs_level[k*GSW +: GSW] = lv[k][GSW-1:0];
    endtask

    // driver: blank interval with colliding steps, then one full frame
    task automatic run_frame(input int lv[CH], input int per, input string tag,
                             input bit chg, input int nlv[CH]);
        set_levels(lv);
        blank = 1'b1;
        for (int i = 0; i < 6; i++) begin
            gs_step = i[0];
            step();
        end
        blank   = 1'b0;
        gs_step = 1'b0;
        frame_id++;
        for (int k = 0; k < CH; k++) begin
            exp_item_t it;
            it.ch     = k;
            it.on_cnt = lv[k] * per;
            it.rise   = (lv[k] == 0) ? -1 : k + 1;
            it.tag    = (lv[k] == 0) ? {tag, "/R3"} : (lv[k] == 4095) ? {tag, "/R4"} : {tag, "/R2"};
            sb_q.push_back(it);
        end
        for (int j = 1; j <= 4096 * per + 24; j++) begin
            step();
            gs_step = (j % per == 0);
            if (chg && j == 1000) set_levels(nlv);
        end
        gs_step = 1'b0;
        check(pwm_en == '0, "R4 all off after count exhausted", int'(pwm_en), 0);
        done_id++;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 200000);
        summary();
    end

    initial begin
        int la[CH], lb[CH], lc[CH], ld[CH];
        rst_n = 1'b0; blank = 1'b1; gs_step = 1'b0; gs_level = '0;
        open_load = '0; thermal = 1'b0;
        step(); step();
        check(pwm_en == '0, "R1 enables in reset", int'(pwm_en), 0);
        check(err_n == 1'b1, "R1 err_n in reset", int'(err_n), 1);
        rst_n = 1'b1;
        step();
        check(pwm_en == '0 && err_n, "R1 state after reset", int'({err_n, pwm_en}), 1 << CH);

        for (int k = 0; k < CH; k++) begin
            la[k] = (k == 0) ? 0 : (k == 1) ? 1 : (k == CH - 1) ? 4095 : k * 251;
            lb[k] = (k * 97 + 5) % 4096;
            lc[k] = 4095 - k * 13;
            ld[k] = 0;
        end

        // R2 R3 R4 R5 R7: mixed codes, step every 2 clocks
        run_frame(la, 2, "R7", 1'b0, ld);

        // R10 R9 R11 with every enable off
        open_load = '1;
        step();
        check(err_n == 1'b1, "R10 open-load on unlit channels ignored", int'(err_n), 1);
        thermal = 1'b1;
        step();
        check(err_n == 1'b0, "R9 thermal asserts error", int'(err_n), 0);
        thermal = 1'b0;
        step();
        check(err_n == 1'b1, "R11 error clears", int'(err_n), 1);

        // R8: codes change mid-frame, old codes must rule
        run_frame(lb, 2, "R8", 1'b1, lc);
        // R8: new codes take effect after blank, step every 3 clocks
        run_frame(lc, 3, "R8", 1'b0, ld);

        // R10 with a lit channel; no steps so channel 5 stays on
        open_load = '0;
        for (int k = 0; k < CH; k++) ld[k] = (k == 5) ? 4095 : 0;
        set_levels(ld);
        blank = 1'b1;
        step(); step(); step();
        blank = 1'b0;
        repeat (12) step();
        check(pwm_en == 16'h0020, "R5 only channel 5 lit", int'(pwm_en), 32);
        open_load = 16'h0001;
        step();
        check(err_n == 1'b1, "R10 open-load on unlit ch0 ignored", int'(err_n), 1);
        open_load = 16'h0020;
        step();
        check(err_n == 1'b0, "R10 open-load on lit ch5 reported", int'(err_n), 0);
        open_load = '0;
        step();
        check(err_n == 1'b1, "R11 error clears after open-load removed", int'(err_n), 1);

        // R6: blank in mid-run forces everything off at the next edge
        blank = 1'b1;
        step();
        check(pwm_en == '0, "R6 blank forces enables off", int'(pwm_en), 0);
        step();
        check(pwm_en == '0, "R6 enables stay off while blanked", int'(pwm_en), 0);
        summary();
    end
endmodule